// File: doc/BRIEF.md
# Separate-I/O Burst-of-Two SRAM Port

This block is a synchronous static memory with a read port and a write port that run independently but share a single pair-address input. Every transaction moves two words: an even word at the pair address with its lowest bit forced to 0, then the odd word at that address with the lowest bit forced to 1. Both port selects are active-low and are looked at only on the rising clock edge. A read and a write may both start in the same cycle.

Write data is double-data-rate. The even word is captured on the rising edge that accepts the write. The odd word is captured on the falling edge that follows. Each beat has its own active-low byte write enables.

Read data is also double-data-rate. It is launched one and a half cycles after the address: the even word appears at the next rising edge and the odd word at the falling edge after that. When nothing is being returned, the read bus reports not-valid and carries zero, which stands in for a high-impedance bus.

Top module: `sio_burst2_sram`

## Requirements
- R1: While reset is active and right after it, `rvalid` is 0 and `rdata` is 0, so both ports come up deselected with the output released.
- R2: `rd_sel_n` and `wr_sel_n` are sampled only at rising clock edges. A select that goes low after a rising edge and returns high before the next one starts no transaction.
- R3: A write accepted at rising edge t stores `wdata` at that edge into word {addr,0}. It stores `wdata` at the falling edge of the same cycle into word {addr,1}.
- R4: A read accepted at rising edge t drives word {addr,0} with `rvalid`=1 from rising edge t+1 to falling edge t+1. It then drives word {addr,1} with `rvalid`=1 from falling edge t+1 to rising edge t+2.
- R5: In any half-cycle that carries no read beat, `rvalid` is 0 and `rdata` is all zeros.
- R6: `wbyte_n[i]`=0 writes byte i (bits 8i+7..8i) of the current beat and `wbyte_n[i]`=1 leaves that byte unchanged. The enables are sampled separately for each beat.
- R7: A burst that has been accepted finishes both beats whatever the selects do afterwards. A write accepted in the cycle after a read does not change the data that read returns.
- R8: When a read and a write are accepted at the same rising edge, the read returns the contents as they were before that write.
- R9: Reads accepted at consecutive rising edges produce an unbroken stream of valid beats, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The rising edge accepts commands and even beats. The falling edge handles odd beats. |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read select, sampled at the rising edge |
| wr_sel_n | input | 1 | Active-low write select, sampled at the rising edge |
| addr | input | PAIR_AW | Word-pair address for both ports |
| wdata | input | DW | Write data for the even beat (rising edge) and the odd beat (falling edge) |
| wbyte_n | input | DW/BYTE_W | Active-low byte write enables, one set per beat |
| rdata | output | DW | Read data, zero when not valid |
| rvalid | output | 1 | High while `rdata` carries a read beat |

## Verification
The bench first fills every pair with a full-mask write. It then aims at the ordering corners. A read and a write to the same pair in one cycle must return pre-write data; a design that snapshots too late would return the new words. A read followed at once by a write to the same pair stresses the odd beat, which is still in flight while the next write's odd beat lands; a design that reads the array at output time would return the overwritten word. A select pulse that straddles only a falling edge would wrongly start a transfer or corrupt a word if the design sampled on both edges. Split byte masks catch a design that reuses the first beat's enables for the second beat. Random interleaving catches latency slips and beat swaps.

// File: rtl/sio_burst2_sram.sv
`timescale 1ns/1ps
module sio_burst2_sram #(
  parameter int PAIR_AW = 5,
  parameter int DW      = 16,
  parameter int BYTE_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_sel_n,
  input  logic                   wr_sel_n,
  input  logic [PAIR_AW-1:0]     addr,
  input  logic [DW-1:0]          wdata,
  input  logic [DW/BYTE_W-1:0]   wbyte_n,
  output logic [DW-1:0]          rdata,
  output logic                   rvalid
);
  localparam int NB    = DW / BYTE_W;
  localparam int PAIRS = 1 << PAIR_AW;

  logic [DW-1:0] even_mem [PAIRS];
  logic [DW-1:0] odd_mem  [PAIRS];

  logic [PAIR_AW-1:0] wa;
  logic               wpend, rpend, q0v, q1v, tp, tn;
  logic [DW-1:0]      s0, s1, h1, q0d, q1d;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [NB-1:0] en_n);
    logic [DW-1:0] r;
    r = old_w;
    for (int b = 0; b < NB; b++)
      if (!en_n[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  always_ff @(posedge clk)
    if (rst_n && !wr_sel_n) even_mem[addr] <= merge(even_mem[addr], wdata, wbyte_n);

  always_ff @(negedge clk)
    if (wpend) odd_mem[wa] <= merge(odd_mem[wa], wdata, wbyte_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tp <= 1'b0; wpend <= 1'b0; rpend <= 1'b0; wa <= '0;
      s0 <= '0; s1 <= '0; q0v <= 1'b0; q0d <= '0; h1 <= '0;
    end else begin
      tp    <= ~tp;
      wpend <= ~wr_sel_n;
      wa    <= addr;
      rpend <= ~rd_sel_n;
      if (!rd_sel_n) begin
        s0 <= even_mem[addr];
        s1 <= odd_mem[addr];
      end
      q0v <= rpend;
      q0d <= rpend ? s0 : '0;
      h1  <= rpend ? s1 : '0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tn <= 1'b0; q1v <= 1'b0; q1d <= '0;
    end else begin
      tn  <= tp;
      q1v <= q0v;
      q1d <= h1;
    end
  end

  assign rvalid = (tp != tn) ? q0v : q1v;
  assign rdata  = (tp != tn) ? q0d : q1d;
endmodule

module sio_burst2_sram_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_sel_n,
  input logic          rvalid,
  input logic [DW-1:0] rdata
);
  logic [1:0] age;
  logic       fh_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) fh_v <= 1'b0;
    else fh_v <= rvalid;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!rvalid && rdata == '0));

  // R4
  read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(!rd_sel_n, 2)) |-> rvalid);

  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(!rd_sel_n, 2)) |-> !rvalid);

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);

  // R4
  beat_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fh_v == rvalid);
endmodule

bind sio_burst2_sram sio_burst2_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rvalid(rvalid), .rdata(rdata)
);

// File: tb/sim_sio_burst2_sram.sv
`timescale 1ns/1ps
module sim_sio_burst2_sram;
  localparam int AW = 5, DW = 16, NB = 2, PAIRS = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, rd_sel_n, wr_sel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [NB-1:0] wbyte_n;
  logic rvalid;

  sio_burst2_sram #(.PAIR_AW(AW), .DW(DW), .BYTE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .wdata(wdata), .wbyte_n(wbyte_n), .rdata(rdata), .rvalid(rvalid)
  );

  int checks = 0, fails = 0;
  logic [DW-1:0] ref_e [PAIRS];
  logic [DW-1:0] ref_o [PAIRS];
  logic cv;
  logic [DW-1:0] c0, c1;

  function automatic logic [DW-1:0] bmerge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                           input logic [NB-1:0] m);
    logic [DW-1:0] r = o;
    for (int b = 0; b < NB; b++) if (!m[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic ev, input logic [DW-1:0] ed);
    checks++;
    if (rvalid !== ev || rdata !== ed) begin
      fails++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               req, rvalid, rdata, ev, ed);
    end
  endtask

  task automatic cyc(input bit rd, input bit wr, input logic [AW-1:0] a,
                     input logic [DW-1:0] w0, input logic [NB-1:0] m0,
                     input logic [DW-1:0] w1, input logic [NB-1:0] m1,
                     input bit glitch, input string req);
    logic nv; logic [DW-1:0] n0, n1;
    rd_sel_n = !rd; wr_sel_n = !wr; addr = a; wdata = w0; wbyte_n = m0;
    nv = rd; n0 = rd ? ref_e[a] : '0; n1 = rd ? ref_o[a] : '0;
    if (wr) begin
      ref_e[a] = bmerge(ref_e[a], w0, m0);
      ref_o[a] = bmerge(ref_o[a], w1, m1);
    end
    @(posedge clk); #2;
    chk(req, cv, c0);
    wdata = w1; wbyte_n = m1;
    rd_sel_n = !glitch; wr_sel_n = !glitch;
    if (glitch) addr = ~a;
    @(negedge clk); #2;
    chk(req, cv, c1);
    cv = nv; c0 = n0; c1 = n1;
  endtask

  initial begin
    #1_600_000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = '0; wdata = '0; wbyte_n = '1;
    cv = 1'b0; c0 = '0; c1 = '0;
    repeat (3) @(posedge clk);
    #2 chk("R1", 1'b0, '0);
    @(negedge clk); rst_n = 1'b1; #2;
    chk("R1", 1'b0, '0);

    // R3: fill every pair with distinct beats
    for (int p = 0; p < PAIRS; p++)
      cyc(0, 1, AW'(p), DW'(16'h1000 + p), 2'b00, DW'(16'h2000 + p), 2'b00, 0, "R3");
    // R9: back-to-back reads
    for (int p = 0; p < PAIRS; p++)
      cyc(1, 0, AW'(p), '0, '1, '0, '1, 0, "R9");
    cyc(0, 0, '0, '0, '1, '0, '1, 0, "R9");
    // R4/R5: isolated read then idles
    cyc(1, 0, 5'd3, '0, '1, '0, '1, 0, "R4");
    cyc(0, 0, '0, 16'hFFFF, '0, 16'hFFFF, '0, 0, "R4");
    cyc(0, 0, '0, 16'hFFFF, '0, 16'hFFFF, '0, 0, "R5");
    // R6: split byte masks
    cyc(0, 1, 5'd7, 16'hAAAA, 2'b01, 16'hBBBB, 2'b10, 0, "R6");
    cyc(1, 0, 5'd7, '0, '1, '0, '1, 0, "R6");
    cyc(0, 0, '0, '0, '1, '0, '1, 0, "R6");
    // R8: same-cycle read and write
    cyc(1, 1, 5'd9, 16'h5A5A, 2'b00, 16'hC3C3, 2'b00, 0, "R8");
    cyc(1, 0, 5'd9, '0, '1, '0, '1, 0, "R8");
    cyc(0, 0, '0, '0, '1, '0, '1, 0, "R8");
    // R2: selects low only across the falling edge
    cyc(0, 0, 5'd4, 16'hDEAD, 2'b00, 16'hBEEF, 2'b00, 1, "R2");
    cyc(0, 0, '0, '0, '1, '0, '1, 0, "R2");
    cyc(1, 0, 5'd4, '0, '1, '0, '1, 0, "R2");
    cyc(1, 0, 5'd27, '0, '1, '0, '1, 0, "R2");
    cyc(0, 0, '0, '0, '1, '0, '1, 0, "R2");
    // R7: write right after a read to the same pair
    cyc(1, 0, 5'd12, '0, '1, '0, '1, 0, "R7");
    cyc(0, 1, 5'd12, 16'h7777, 2'b00, 16'h8888, 2'b00, 0, "R7");
    cyc(1, 0, 5'd12, '0, '1, '0, '1, 0, "R7");
    cyc(0, 0, '0, '0, '1, '0, '1, 0, "R7");
    // R7: random interleaving
    for (int i = 0; i < 400; i++)
      cyc(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), AW'($urandom),
          DW'($urandom), NB'($urandom), DW'($urandom), NB'($urandom), 0, "R7");
    cyc(0, 0, '0, '0, '1, '0, '1, 0, "R7");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule